// File: doc/BRIEF.md
# Serial 1011 Pattern Detector

This block watches a one-bit serial stream that is sampled on every rising clock edge. It raises a one-cycle flag each time the four most recent samples, oldest first, read 1, 0, 1, 1. Patterns that share bits are each reported. In 1011011, the last 1 of the first pattern also begins the second. In 10111011 the two patterns simply follow each other. Both streams give two flags.

The detector is a five-state Moore machine. Its state names how much of the pattern has been seen so far. The flag comes only from the state that means "pattern complete". It is held in a register next to the state, so the flag changes on a clock edge and never depends combinationally on the input. Once the pattern is complete, the machine does not go back to idle. It goes straight to the partial-match state that the newest bit implies. State encodings that are never used lead back to idle, and the flag is clear in those states.

Top module: `serial_pattern_detector`

## Requirements
- R1: At a clock edge where `rst` is 1, the machine goes to idle (state encoding 0 in its 3-bit state register) and `match_out` is 0 in the cycle that follows. Bits sampled before the reset are forgotten.
- R2: `match_out` is 1 in the cycle after the edge at which the last four bits sampled since reset, oldest first, were 1,0,1,1. In every other cycle it is 0.
- R3: Patterns that share bits are each reported. The trailing 1 of a completed pattern counts as the first bit of the next one, so 1011011 gives flags 3 cycles apart and 10111011 gives flags 4 cycles apart.
- R4: From idle, a sampled 0 keeps the machine in idle and a sampled 1 moves it to the "1 seen" state. No flag is raised on either step.
- R5: `match_out` is never 1 in two cycles in a row.
- R6: The state register only ever holds the five legal encodings 0 to 4. The flag is 1 only while the state is 4 ("pattern complete").
- R7: After a completed pattern, a sampled 1 moves the machine to the "1 seen" state (1) and a sampled 0 moves it to the "10 seen" state (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit, sampled every rising edge |
| match_out | output | 1 | Registered flag: 1 for one cycle after the pattern completes |

## Verification
Every result is due exactly one cycle after the edge that samples the completing bit. The flag is the only register between `bit_in` and `match_out`. The bench drives each bit just after a falling edge. At the next falling edge it compares `match_out` against a behavioural history of the bits it has driven, so each comparison falls half a period after the register has updated. Reset cycles clear that history the same way R1 clears the machine. Directed streams cover overlapping patterns, idle behaviour and reset in the middle of a pattern, and a long random stream follows them.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int unsigned SD_STATE_W = 3;
    localparam int unsigned SD_NUM_ST  = 5;

    typedef enum logic [SD_STATE_W-1:0] {
        SD_IDLE  = 3'd0,
        SD_GOT1  = 3'd1,
        SD_GOT10 = 3'd2,
        SD_GOT101 = 3'd3,
        SD_FULL  = 3'd4
    } sd_state_e;

    typedef struct packed {
        sd_state_e state;
        logic      flag;
    } sd_regs_t;

    localparam sd_regs_t SD_RESET_VAL = '{state: SD_IDLE, flag: 1'b0};

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  sd_state_e cur_state,
    input  logic      bit_in,
    output sd_state_e nxt_state
);

    always_comb begin
        case (cur_state)
            SD_IDLE:   nxt_state = bit_in ? SD_GOT1   : SD_IDLE;
            SD_GOT1:   nxt_state = bit_in ? SD_GOT1   : SD_GOT10;
            SD_GOT10:  nxt_state = bit_in ? SD_GOT101 : SD_IDLE;
            SD_GOT101: nxt_state = bit_in ? SD_FULL   : SD_GOT10;
            SD_FULL:   nxt_state = bit_in ? SD_GOT1   : SD_GOT10;
            default:   nxt_state = SD_IDLE;
        endcase
    end

endmodule

// File: rtl/seqdet_flag.sv
module seqdet_flag
    import seqdet_pkg::*;
(
    input  sd_state_e nxt_state,
    output logic      nxt_flag
);

    always_comb begin
        case (nxt_state)
            SD_FULL: nxt_flag = 1'b1;
            default: nxt_flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_pattern_detector.sv
module serial_pattern_detector
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);

    sd_regs_t  regs_d;
    sd_regs_t  regs_q;
    sd_state_e step_state;
    logic      step_flag;

    seqdet_next u_next (
        .cur_state (regs_q.state),
        .bit_in    (bit_in),
        .nxt_state (step_state)
    );

    seqdet_flag u_flag (
        .nxt_state (step_state),
        .nxt_flag  (step_flag)
    );

    always_comb begin
        regs_d.state = step_state;
        regs_d.flag  = step_flag;
        if (rst) begin
            regs_d = SD_RESET_VAL;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign match_out = regs_q.flag;

endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_in,
    input logic       match_out,
    input logic [2:0] state_q
);

    logic [3:0] hist_q;
    logic       prev_rst_q;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
        if (rst) hist_q <= 4'b0000;
        else     hist_q <= {hist_q[2:0], bit_in};
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        (prev_rst_q === 1'b1) |-> (state_q == 3'd0 && !match_out)); // R1

    AST_FLAG_MATCHES_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (prev_rst_q === 1'b0) |-> (match_out == (hist_q == 4'b1011))); // R2

    AST_IDLE_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd0 && !bit_in) |=> (state_q == 3'd0 && !match_out)); // R4

    AST_IDLE_ONE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd0 && bit_in) |=> (state_q == 3'd1 && !match_out)); // R4

    AST_NO_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (rst)
        match_out |=> !match_out); // R5

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
        (prev_rst_q === 1'b0) |-> (state_q <= 3'd4)); // R6

    AST_FLAG_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        match_out |-> (state_q == 3'd4)); // R6

    AST_FULL_ONE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd4 && bit_in) |=> (state_q == 3'd1)); // R3 R7

    AST_FULL_ZERO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd4 && !bit_in) |=> (state_q == 3'd2)); // R7

endmodule

bind serial_pattern_detector seqdet_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .match_out (match_out),
    .state_q   (regs_q.state)
);

// File: tb/serial_pattern_detector_tb.sv
module serial_pattern_detector_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic match_out;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_valid = 1'b0;
    bit exp_flag = 1'b0;
    bit prev_seen = 1'b0;
    bit finished = 1'b0;
    int flags_seen = 0;
    bit hist[$];

    always #2 clk = ~clk;

    serial_pattern_detector u_dut (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .match_out (match_out)
    );

    task automatic step(input bit b, input bit r, input string tag);
        @(negedge clk);
        if (exp_valid) begin
            n_chk++;
            if (match_out !== exp_flag) begin
                n_bad++;
                $display("FAIL %s: match_out=%b expected %b", tag, match_out, exp_flag);
            end
            n_chk++;
            if (prev_seen && match_out === 1'b1) begin
                n_bad++;
                $display("FAIL R5: match_out=1 in two cycles, expected 0");
            end
            prev_seen = (match_out === 1'b1);
            if (match_out === 1'b1) flags_seen++;
        end
        rst = r;
        bit_in = b;
        if (r) begin
            hist.delete();
            exp_flag = 1'b0;
        end else begin
            hist.push_back(b);
            if (hist.size() > 4) void'(hist.pop_front());
            exp_flag = (hist.size() == 4) && hist[0] && !hist[1] && hist[2] && hist[3];
        end
        exp_valid = 1'b1;
    endtask

    task automatic send(input string pat, input string tag);
        for (int i = 0; i < pat.len(); i++) step(pat[i] == "1", 1'b0, tag);
    endtask

    task automatic expect_count(input int want, input string tag);
        n_chk++;
        if (flags_seen != want) begin
            n_bad++;
            $display("FAIL %s: flag count=%0d expected %0d", tag, flags_seen, want);
        end
    endtask

    initial begin
        step(1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        send("0000", "R4");
        send("1000", "R4");
        flags_seen = 0;
        send("10110000", "R2");
        expect_count(1, "R2");
        step(1'b0, 1'b1, "R1");
        flags_seen = 0;
        send("10111011000", "R3");
        expect_count(2, "R3");
        step(1'b0, 1'b1, "R1");
        flags_seen = 0;
        send("1011011000", "R3");
        expect_count(2, "R3");
        step(1'b0, 1'b1, "R1");
        flags_seen = 0;
        send("11101100101100", "R7");
        expect_count(2, "R7");
        step(1'b0, 1'b1, "R6");
        flags_seen = 0;
        send("101", "R1");
        step(1'b1, 1'b1, "R1");
        send("100", "R1");
        expect_count(0, "R1");
        for (int i = 0; i < 4000; i++) begin
            step(1'($urandom_range(0, 1)), (i % 997) == 500, "R2");
        end
        step(1'b0, 1'b0, "R2");
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule